// File: doc/BRIEF.md
# Reference-Path Programmable Modulus Divider

This block sits in front of a phase/frequency detector and produces the detector's reference signal. It counts cycles of the oscillator clock and emits a single-cycle pulse once per division period. The period is a programmed 7-bit value plus two, which gives a usable modulus from 3 to 129. A programmed value of 0 would give a modulus of 2, so it is clamped up to 3. A select bit chooses what drives the reference output: the divider's pulse train, or an external horizontal-sync input passed straight through.

The modulus value and the select bit are held in a small configuration register. That register loads both fields from the configuration inputs on any clock edge where the write strobe is high. After reset the select bit is 1, which chooses the divider, and the modulus value is 0. A newly written modulus does not disturb a division period that is already running. The counter takes the new value only at its next wrap, so every period that starts also completes. The block has no streaming data path. Every pin is a plain control or clock-rate signal, with no valid/ready handshake and no back-pressure.

Top module: `refdiv_top`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, `ref_o` is 0. After reset the select resets to 1 (divider) and the modulus value to 0. The counter restarts from zero, so the first pulse is visible after the third rising edge following release.
- R2: For a programmed value V in 1..127, the divider period is exactly V+2 clock cycles.
- R3: A programmed value of 0 gives a period of 3 cycles, not 2.
- R4: In each period, the divider output is high for exactly one clock cycle, in the last cycle of the period, and low for the other cycles.
- R5: A modulus written while a period is running takes effect only after that period ends. The period in progress keeps its old length.
- R6: When the select bit is 0, `ref_o` equals `hsync_i` in the same cycle. The divider keeps counting, so its phase is unchanged when the divider is selected again.
- R7: When the select bit is 1, `ref_o` is the divider pulse, and `hsync_i` has no effect on it.
- R8: The modulus value and the select bit change only on an edge where `cfg_we_i` is 1. Changes on `cfg_mod_i` and `cfg_sel_i` while the strobe is low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load strobe for modulus value and select |
| cfg_mod_i | input | 7 | Programmed value; modulus = value + 2, minimum 3 |
| cfg_sel_i | input | 1 | Reference source: 0 = horizontal sync, 1 = divider |
| hsync_i | input | 1 | External horizontal-sync reference |
| ref_o | output | 1 | Reference to the phase/frequency detector |

## Verification
The assertions check the following on every cycle:
- the counter never reaches the active modulus;
- the counter steps by one, or returns to zero only on a wrap;
- the active modulus never drops below 3 and changes only at a wrap;
- the divider pulse never lasts two cycles;
- the configuration holds when the strobe is low.

The exact period length for a given programmed value needs the bench's scenarios. So do the clamp of value 0, the old period finishing after a mid-period write, the pass-through and ignoring of the sync input, and the restart after a mid-period reset. The bench checks these by comparing `ref_o`, cycle by cycle, against pulse trains it builds from the requirements.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  parameter int unsigned DEF_MOD_W   = 7;
  parameter int unsigned DEF_OFFSET  = 2;
  parameter int unsigned DEF_MIN_MOD = 3;

  typedef enum logic {
    SRC_HSYNC = 1'b0,
    SRC_DIV   = 1'b1
  } ref_src_e;
endpackage

// File: rtl/refdiv_cfg.sv
module refdiv_cfg
  import refdiv_pkg::*;
#(
  parameter int unsigned MOD_W = DEF_MOD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic             sel_i,
  output logic [MOD_W-1:0] mod_q,
  output ref_src_e         sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0;
      sel_q <= SRC_DIV;
    end else if (we_i) begin
      mod_q <= mod_i;
      sel_q <= sel_i ? SRC_DIV : SRC_HSYNC;
    end
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
  import refdiv_pkg::*;
#(
  parameter int unsigned MOD_W   = DEF_MOD_W,
  parameter int unsigned OFFSET  = DEF_OFFSET,
  parameter int unsigned MIN_MOD = DEF_MIN_MOD,
  parameter int unsigned CNT_W   = $clog2((2**MOD_W) + OFFSET)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MOD_W-1:0] mod_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_mod_o,
  output logic             wrap_o,
  output logic             pulse_o
);
  localparam logic [CNT_W-1:0] OFS_C = CNT_W'(OFFSET);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_MOD);
  localparam logic [CNT_W-1:0] RST_MOD = (OFS_C < MIN_C) ? MIN_C : OFS_C;

  logic [CNT_W-1:0] raw_mod;
  logic [CNT_W-1:0] eff_mod;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_q;
  logic             pulse_q;

  always_comb begin
    raw_mod = CNT_W'(mod_val_i) + OFS_C;
    eff_mod = (raw_mod < MIN_C) ? MIN_C : raw_mod;
  end

  assign wrap_o = (cnt_q == act_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_q   <= RST_MOD;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap_o;
      if (wrap_o) begin
        cnt_q <= '0;
        act_q <= eff_mod;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign act_mod_o = act_q;
  assign pulse_o   = pulse_q;
endmodule

// File: rtl/refdiv_select.sv
module refdiv_select
  import refdiv_pkg::*;
(
  input  ref_src_e src_i,
  input  logic     hsync_i,
  input  logic     pulse_i,
  output logic     ref_o
);
  always_comb begin
    unique case (src_i)
      SRC_HSYNC: ref_o = hsync_i;
      default:   ref_o = pulse_i;
    endcase
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int unsigned MOD_W   = DEF_MOD_W,
  parameter int unsigned OFFSET  = DEF_OFFSET,
  parameter int unsigned MIN_MOD = DEF_MIN_MOD,
  localparam int unsigned CNT_W  = $clog2((2**MOD_W) + OFFSET)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [MOD_W-1:0] cfg_mod_i,
  input  logic             cfg_sel_i,
  input  logic             hsync_i,
  output logic             ref_o
);
  logic [MOD_W-1:0] mod_q;
  ref_src_e         sel_q;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] act_mod_w;
  logic             wrap_w;
  logic             pulse_w;

  refdiv_cfg #(.MOD_W(MOD_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (cfg_we_i),
    .mod_i (cfg_mod_i),
    .sel_i (cfg_sel_i),
    .mod_q (mod_q),
    .sel_q (sel_q)
  );

  refdiv_counter #(
    .MOD_W   (MOD_W),
    .OFFSET  (OFFSET),
    .MIN_MOD (MIN_MOD),
    .CNT_W   (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_val_i (mod_q),
    .cnt_o     (cnt_w),
    .act_mod_o (act_mod_w),
    .wrap_o    (wrap_w),
    .pulse_o   (pulse_w)
  );

  refdiv_select u_sel (
    .src_i   (sel_q),
    .hsync_i (hsync_i),
    .pulse_i (pulse_w),
    .ref_o   (ref_o)
  );
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker #(
  parameter int unsigned MOD_W   = 7,
  parameter int unsigned MIN_MOD = 3,
  parameter int unsigned CNT_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [MOD_W-1:0] mod_q,
  input logic             sel_q,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_mod,
  input logic             wrap,
  input logic             pulse
);
  AST_CNT_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < act_mod); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> cnt == $past(cnt) + CNT_W'(1)); // R2
  AST_CNT_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0) && pulse); // R4
  AST_MOD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    act_mod >= CNT_W'(MIN_MOD)); // R3
  AST_MOD_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_mod)); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R4
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mod_q) && $stable(sel_q)); // R8
endmodule

bind refdiv_top refdiv_checker #(
  .MOD_W   (MOD_W),
  .MIN_MOD (MIN_MOD),
  .CNT_W   (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_we  (cfg_we_i),
  .mod_q   (mod_q),
  .sel_q   (sel_q),
  .cnt     (cnt_w),
  .act_mod (act_mod_w),
  .wrap    (wrap_w),
  .pulse   (pulse_w)
);

// File: tb/tb_refdiv_top.sv
module tb_refdiv_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [6:0] cfg_mod_i = '0;
  logic       cfg_sel_i = 1'b1;
  logic       hsync_i = 1'b0;
  logic       ref_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  refdiv_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we_i  (cfg_we_i),
    .cfg_mod_i (cfg_mod_i),
    .cfg_sel_i (cfg_sel_i),
    .hsync_i   (hsync_i),
    .ref_o     (ref_o)
  );

  // Monitor: one expected item per falling edge, compared just after it.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (ref_o !== it.exp) begin
          n_bad++;
          $display("FAIL %s: ref_o=%0b expected=%0b at %0t", it.tag, ref_o, it.exp, $time);
        end
      end
    end
  end

  task automatic push(input bit e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // One divider period of m cycles: m-1 low samples, then the pulse.
  task automatic period(input int m, input string tag, input bit wiggle);
    for (int i = 0; i < m; i++) begin
      @(negedge clk);
      cfg_we_i = 1'b0;
      if (wiggle) hsync_i = ~hsync_i;
      push(i == m - 1, tag);
    end
  endtask

  // Called at the falling edge where a pulse was just pushed.
  task automatic write_cfg(input logic [6:0] v, input bit s);
    cfg_mod_i = v;
    cfg_sel_i = s;
    cfg_we_i  = 1'b1;
  endtask

  initial begin
    // R1: output low during reset
    repeat (2) begin
      @(negedge clk);
      push(1'b0, "R1");
    end
    @(negedge clk);
    rst_n = 1'b1;
    push(1'b0, "R1");
    period(3, "R1", 1'b0);
    period(3, "R3", 1'b0);
    // R5: period running at the write keeps the old length
    write_cfg(7'd5, 1'b1);
    period(3, "R5", 1'b0);
    period(7, "R2", 1'b0);
    period(7, "R4", 1'b0);
    write_cfg(7'd127, 1'b1);
    period(7, "R5", 1'b0);
    period(129, "R2", 1'b0);
    write_cfg(7'd1, 1'b1);
    period(129, "R5", 1'b0);
    period(3, "R2", 1'b0);
    // R8: input changes without the strobe are ignored
    cfg_mod_i = 7'd10;
    cfg_sel_i = 1'b0;
    period(3, "R8", 1'b0);
    period(3, "R8", 1'b0);
    // R6: select horizontal sync; divider keeps its period-3 phase
    write_cfg(7'd1, 1'b0);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      cfg_we_i = 1'b0;
      hsync_i = (i % 3 == 1) || (i == 4);
      push(hsync_i, "R6");
    end
    write_cfg(7'd1, 1'b1);
    // R7: sync toggling has no effect with the divider selected
    period(3, "R7", 1'b1);
    period(3, "R7", 1'b1);
    // R3: value 0 written back gives period 3
    write_cfg(7'd0, 1'b1);
    period(3, "R3", 1'b0);
    period(3, "R3", 1'b0);
    // R1: reset in mid-period restarts counting and config
    write_cfg(7'd127, 1'b1);
    @(negedge clk);
    cfg_we_i = 1'b0;
    push(1'b0, "R1");
    @(negedge clk);
    push(1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b0;
    push(1'b0, "R1");
    @(negedge clk);
    push(1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    push(1'b0, "R1");
    period(3, "R1", 1'b0);
    period(3, "R1", 1'b0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule